// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked on-chip requester and an external asynchronous static RAM that is organised as 1M words of 16 bits. The requester presents a 20-bit word address, a read/write flag, 16 bits of write data and a two-bit byte mask through a valid/ready handshake. The controller turns each accepted request into a correctly timed sequence on the memory's active-low chip select, write enable, output enable and two byte-lane enables. Read data comes back with a one-cycle valid strobe.

All nanosecond limits are parameters. The controller converts each one into a clock-cycle count by rounding the required time divided by the clock period up to a whole number of cycles. After reset it holds the memory in standby for the power-up interval before it accepts any request.

A write is the window in which chip select, at least one byte enable and write enable are all low. The controller opens that window only after it has driven the address and data. It closes the window by raising write enable while the data is still driven. Output enable stays high for the whole write. After every read, one cycle with the memory deselected lets the memory release the bus before the controller can drive it.

States and transitions of the controller:

| State | Meaning |
|---|---|
| ST_POWERUP | Reset hold-off; leaves for ST_IDLE once the power-up counter reaches zero |
| ST_IDLE | Standby and ready; a read request goes to ST_RD_ACCESS, a write request goes to ST_WR_SETUP |
| ST_RD_ACCESS | Chip select and output enable low for RD_CYC cycles; at the last edge the data is captured and the state goes to ST_RD_TURN |
| ST_RD_TURN | One deselected cycle so the memory releases the bus, then ST_IDLE |
| ST_WR_SETUP | Address, byte enables and data driven with write enable high, then ST_WR_PULSE |
| ST_WR_PULSE | Write enable low for WP_CYC cycles, then ST_WR_HOLD |
| ST_WR_HOLD | Write enable high while the data stays driven, then ST_IDLE |

Top module: `asram_ctrl`

## Requirements
- R1: After reset is released, req_ready stays low and mem_cs_n stays high for at least PU_CYC = ceil(150 us / clock period) cycles, which is 30000 cycles at 200 MHz. req_ready rises no later than PU_CYC+2 cycles after release.
- R2: req_ready is high only in the idle state. Once a request is accepted (req_valid and req_ready high at a rising edge), req_ready is low in the next cycle and stays low until the access has finished.
- R3: A read holds mem_cs_n and mem_oe_n low and mem_we_n high for RD_CYC = 2 cycles, with mem_addr equal to the requested address. rd_valid is high for exactly one cycle, starting RD_CYC edges after the accepting edge, and it carries the data seen at the memory pins.
- R4: A write drives mem_addr and mem_dq_out with mem_dq_oe high for one cycle before mem_we_n falls. It holds mem_we_n low for WP_CYC = 2 cycles with the address and data stable. It then keeps mem_cs_n low and the data driven for one more cycle after mem_we_n rises. req_ready returns WP_CYC+2 cycles after acceptance.
- R5: Mask bit 0 controls mem_lb_n, which covers data bits 7:0. Mask bit 1 controls mem_ub_n, which covers data bits 15:8. An enable is driven low during an access only when its mask bit is 1, so a write with one mask bit changes only that lane.
- R6: A write with mask 2'b00 leaves the memory contents unchanged.
- R7: In a read, rd_data bits of a lane whose mask bit is 0 are returned as zero.
- R8: mem_oe_n is high whenever mem_we_n is low or mem_dq_oe is high.
- R9: Every read is followed by one cycle with mem_cs_n and mem_oe_n high and the bus not driven before the controller returns to idle, so req_ready returns RD_CYC+1 cycles after acceptance. The cycle in which mem_oe_n rises never has mem_dq_oe high.
- R10: While the controller is idle, mem_cs_n, mem_we_n and mem_oe_n are high and mem_dq_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_data | output | 16 | Read data, unselected lanes zero |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | 20 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
A wrong state shows up at the pins in the cycle where it takes effect. A skipped setup cycle makes write enable fall in the same cycle the bus starts being driven. A missing turnaround brings req_ready back one cycle early after a read. A wrong pulse count changes the number of cycles with write enable low. A wrong lane decode appears as a corrupted neighbour byte on the next read-back, only a few cycles later. A power-up counter that stops too soon raises req_ready before the 30000th cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } asram_state_e;

    // Whole clock cycles covering a time in ns, never below one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ps);
        int c;
        c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_down_timer.sv
module asram_down_timer #(
    parameter int WIDTH    = 4,
    parameter int INIT_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= WIDTH'(INIT_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_mask.sv
module asram_lane_mask #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES-1:0]        keep,
    output logic [LANES*LANE_W-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*LANE_W +: LANE_W] = keep[i] ? din[i*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int CLK_PS    = 5000,
    parameter int T_PU_NS   = 150000,
    parameter int T_RC_NS   = 10,
    parameter int T_AA_NS   = 10,
    parameter int T_PWE_NS  = 8,
    parameter int T_SD_NS   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;
    localparam int RD_CYC = max2(ns_to_cycles(T_RC_NS, CLK_PS), ns_to_cycles(T_AA_NS, CLK_PS));
    localparam int WP_CYC = max2(ns_to_cycles(T_PWE_NS, CLK_PS), ns_to_cycles(T_SD_NS, CLK_PS));
    localparam int PU_CYC = ns_to_cycles(T_PU_NS, CLK_PS);
    localparam int PU_W   = $clog2(PU_CYC + 1);
    localparam int PH_W   = $clog2(max2(RD_CYC, WP_CYC) + 1);

    asram_state_e      state_q, state_d;
    logic              pu_done, ph_done, ph_load;
    logic [PH_W-1:0]   ph_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, rd_masked;
    logic [LANES-1:0]  mask_q;
    logic              rvalid_q;
    logic              lanes_on;

    asram_down_timer #(.WIDTH(PU_W), .INIT_VAL(PU_CYC)) u_pu_timer (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .expired(pu_done)
    );

    asram_down_timer #(.WIDTH(PH_W), .INIT_VAL(0)) u_phase_timer (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_done)
    );

    asram_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_mask (
        .din(mem_dq_in), .keep(mask_q), .dout(rd_masked)
    );

    // Next state and phase counter loads.
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            ST_POWERUP:   if (pu_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACCESS: if (ph_done) state_d = ST_RD_TURN;
            ST_RD_TURN:   state_d = ST_IDLE;
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                ph_load = 1'b1;
                ph_val  = PH_W'(WP_CYC - 1);
            end
            ST_WR_PULSE:  if (ph_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   state_d = ST_IDLE;
            default:      state_d = ST_POWERUP;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    // Request latch and read capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            mask_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
            rvalid_q <= (state_q == ST_RD_ACCESS) && ph_done;
            if ((state_q == ST_RD_ACCESS) && ph_done) rdata_q <= rd_masked;
        end
    end

    // Pin decode from state.
    always_comb begin
        req_ready = 1'b0;
        mem_cs_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        lanes_on  = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_RD_ACCESS: begin mem_cs_n = 1'b0; mem_oe_n = 1'b0; lanes_on = 1'b1; end
            ST_WR_SETUP,
            ST_WR_HOLD:   begin mem_cs_n = 1'b0; mem_dq_oe = 1'b1; lanes_on = 1'b1; end
            ST_WR_PULSE:  begin mem_cs_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; lanes_on = 1'b1; end
            default:      ;
        endcase
    end

    assign mem_lb_n   = !(lanes_on && mask_q[0]);
    assign mem_ub_n   = !(lanes_on && mask_q[1]);
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rd_data    = rdata_q;
    assign rd_valid   = rvalid_q;

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r4_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));
    a_r4_driven_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_dq_oe));
    a_r8_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    a_r8_oe_off_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    a_r9_turn_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !mem_dq_oe);
    a_r10_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_dq_oe && mem_we_n));
endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb_top;
    localparam int RD_CYC = 2;
    localparam int WP_CYC = 2;
    localparam int PU_CYC = 30000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data, mem_dq_out, mem_dq_in;
    logic [19:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;

    int checks = 0, fails = 0;
    int we_run = 0, last_pulse = 0;
    int viol_oe = 0, viol_setup = 0, viol_idle = 0, viol_pu = 0;
    bit in_pu = 1'b1;
    bit prev_we_n = 1'b1, prev_dq_oe = 1'b0;
    logic [15:0] mem [0:255];

    always #2.5 clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: disabled lanes return a junk pattern.
    assign mem_dq_in = (!mem_cs_n && mem_we_n && !mem_oe_n) ?
        {(!mem_ub_n ? mem[mem_addr[7:0]][15:8] : 8'hA5),
         (!mem_lb_n ? mem[mem_addr[7:0]][7:0]  : 8'hA5)} : 16'hA5A5;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_we_n) begin
                if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
                if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
            end
            if (!mem_we_n) we_run++;
            if (mem_we_n && !prev_we_n) begin last_pulse = we_run; we_run = 0; end
            if ((!mem_we_n || mem_dq_oe) && !mem_oe_n) viol_oe++;
            if (!mem_we_n && prev_we_n && !prev_dq_oe) viol_setup++;
            if (req_ready && (!mem_cs_n || !mem_we_n || !mem_oe_n || mem_dq_oe)) viol_idle++;
            if (in_pu && !mem_cs_n) viol_pu++;
            prev_we_n  = mem_we_n;
            prev_dq_oe = mem_dq_oe;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rdat,
                        output int lat, output int rec);
        int n = 0;
        int pulses = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready low after accept", req_ready, 0);
        chk(wr ? "R4 address on pins" : "R3 address on pins", mem_addr, a);
        lat = -1; rdat = '0;
        while (!req_ready && n < 50) begin
            if (rd_valid) begin lat = n; rdat = rd_data; pulses++; end
            @(negedge clk);
            n++;
        end
        rec = n;
        chk("R3 rd_valid pulse count", pulses, wr ? 0 : 1);
    endtask

    task automatic t_powerup;
        int n = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", req_ready, 0);
        rst_n = 1'b1;
        while (!req_ready && n < PU_CYC + 10) begin @(negedge clk); n++; end
        in_pu = 1'b0;
        chk("R1 hold-off not too short", (n >= PU_CYC), 1);
        chk("R1 hold-off not too long", (n <= PU_CYC + 2), 1);
        chk("R1 no chip select during hold-off", viol_pu, 0);
    endtask

    task automatic t_standby;
        @(negedge clk);
        chk("R10 idle pins", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic t_word_write_read;
        logic [15:0] r; int lat, rec;
        xfer(1'b1, 20'hABC10, 16'hBEEF, 2'b11, r, lat, rec);
        chk("R4 write pulse width", last_pulse, WP_CYC);
        chk("R4 write ready recovery", rec, WP_CYC + 2);
        xfer(1'b0, 20'hABC10, 16'h0, 2'b11, r, lat, rec);
        chk("R3 read data", r, 16'hBEEF);
        chk("R3 read latency", lat, RD_CYC);
        chk("R9 read ready recovery", rec, RD_CYC + 1);
    endtask

    task automatic t_byte_write;
        logic [15:0] r; int lat, rec;
        xfer(1'b1, 20'hABC10, 16'h1234, 2'b01, r, lat, rec);
        xfer(1'b0, 20'hABC10, 16'h0, 2'b11, r, lat, rec);
        chk("R5 lower lane write", r, 16'hBE34);
        xfer(1'b1, 20'hABC10, 16'h5678, 2'b10, r, lat, rec);
        xfer(1'b0, 20'hABC10, 16'h0, 2'b11, r, lat, rec);
        chk("R5 upper lane write", r, 16'h5634);
    endtask

    task automatic t_empty_mask;
        logic [15:0] r; int lat, rec;
        xfer(1'b1, 20'hABC10, 16'hFFFF, 2'b00, r, lat, rec);
        xfer(1'b0, 20'hABC10, 16'h0, 2'b11, r, lat, rec);
        chk("R6 empty mask write", r, 16'h5634);
    endtask

    task automatic t_lane_read;
        logic [15:0] r; int lat, rec;
        xfer(1'b0, 20'hABC10, 16'h0, 2'b01, r, lat, rec);
        chk("R7 lower lane read", r, 16'h0034);
        xfer(1'b0, 20'hABC10, 16'h0, 2'b10, r, lat, rec);
        chk("R7 upper lane read", r, 16'h5600);
    endtask

    task automatic t_pattern;
        logic [15:0] r; int lat, rec;
        for (int i = 0; i < 4; i++)
            xfer(1'b1, 20'h5A000 + 20'(i * 3), 16'(i * 16'h1111 + 16'h0F0F), 2'b11, r, lat, rec);
        for (int i = 0; i < 4; i++) begin
            xfer(1'b0, 20'h5A000 + 20'(i * 3), 16'h0, 2'b11, r, lat, rec);
            chk("R3 pattern read back", r, 16'(i * 16'h1111 + 16'h0F0F));
        end
    endtask

    task automatic t_pin_rules;
        chk("R8 output enable during writes", viol_oe, 0);
        chk("R4 data driven before pulse", viol_setup, 0);
        chk("R10 standby while ready", viol_idle, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        t_powerup();
        t_standby();
        t_word_write_read();
        t_byte_write();
        t_empty_mask();
        t_lane_read();
        t_pattern();
        t_standby();
        t_pin_rules();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule